// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits at the head of a receive path and decides, one frame at a time, whether the frame should be kept. The destination address arrives as a byte stream, first byte first. A start strobe marks the first byte and a valid strobe qualifies every byte. While the bytes stream in, the block runs the Ethernet CRC-32 over them one byte per clock. It also shifts them into an address register. After the sixth byte it produces a single accept or reject verdict.

The verdict follows this priority. Promiscuous mode accepts everything. The all-ones broadcast address is always accepted. A group address, marked by bit 0 of the first byte being 1, is accepted in all-multicast mode. Otherwise, in hashed mode, it is accepted when the 64-bit table has a 1 at the index taken from the top six CRC bits. An individual address is accepted only when it equals the station address. The mode bits and the hash table are sampled with the start byte, so writes made while a frame is in progress only affect the next frame.

The controller is a four-state machine. IDLE waits after reset. COLLECT takes address bytes. DECIDE presents the verdict for one cycle. HOLD ignores the remaining bytes of the frame. Its transitions are:
- start-with-valid, taken from any state: goes to COLLECT and counts the first byte.
- sixth-byte: COLLECT to DECIDE.
- verdict-done: DECIDE to HOLD.
- IDLE and HOLD stay where they are until a start-with-valid.

Top module: `rx_dest_filter`

## Requirements
- R1: The hash index is bits 31:26 of the CRC register after the six destination bytes. The register starts at all ones, uses polynomial 0x04C11DB7, takes the bits of each byte LSB first and has no final inversion. In hashed mode a group, non-broadcast frame is accepted exactly when `hash_table[index]` is 1.
- R2: With `promisc_en` set, every frame is accepted, whatever its address, table or other mode bits.
- R3: With `all_mcast_en` set, every frame whose group bit (bit 0 of the first byte, bit 40 of the 48-bit value) is 1 is accepted without consulting the table.
- R4: An individual-address frame is accepted only when its six bytes equal `station_addr`, which holds the first byte in bits 47:40 and the last in bits 7:0. Any other individual address is rejected unless R2 applies.
- R5: The broadcast address FF:FF:FF:FF:FF:FF is accepted with all mode bits clear.
- R6: `filt_valid` is high for exactly one cycle, the cycle after the clock edge that takes the sixth byte. Bytes after the sixth produce no further verdict until the next start. A group, non-broadcast frame with all three mode bits clear is rejected.
- R7: A byte carrying `rx_start` with `rx_valid` restarts the CRC and the byte count, even in the middle of a frame or in the verdict cycle. `rx_start` without `rx_valid` has no effect.
- R8: The mode bits and `hash_table` are sampled at the start byte. Changing them during a frame does not alter that frame's verdict.
- R9: After reset `filt_valid` is 0 until a full address has been received.
- R10: Cycles with `rx_valid` low are not counted as bytes and do not advance the CRC, so gaps between bytes do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_start | input | 1 | Marks the first destination byte (only with rx_valid) |
| rx_valid | input | 1 | Byte qualifier |
| rx_byte | input | 8 | Destination byte, first transmitted first |
| station_addr | input | 48 | Own individual address, first byte in bits 47:40 |
| hash_table | input | 64 | Multicast hash table, one bit per index |
| promisc_en | input | 1 | Accept every frame |
| all_mcast_en | input | 1 | Accept every group-address frame |
| hash_mcast_en | input | 1 | Accept group frames whose hash bit is set |
| filt_valid | output | 1 | One-cycle verdict strobe |
| filt_accept | output | 1 | Verdict, valid while filt_valid is high |

## Verification
Two functions can coincide in one cycle: presenting the verdict of one frame and taking the start byte of the next. The bench provokes this by driving the next start byte exactly in the DECIDE cycle. It then judges that the first frame's verdict is intact in that cycle and that the second frame's verdict, for a different address class, arrives six bytes later. A restart in the middle of COLLECT, and configuration writes in the middle of a frame, are judged the same way: against a reference CRC and a priority model written independently in the bench.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_HOLD    = 2'd3
    } flt_state_e;

    typedef struct packed {
        logic promisc;
        logic all_mcast;
        logic hash_mcast;
    } flt_mode_t;

    // One byte through the CRC register, data bits taken LSB first.
    function automatic logic [31:0] crc_byte_step(input logic [31:0] cur,
                                                  input logic [7:0]  b);
        logic [31:0] r;
        logic        fb;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/daf_crc_engine.sv
module daf_crc_engine
    import daf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_i,
    input  logic                 take_i,
    input  logic [7:0]           byte_i,
    output logic [HASH_BITS-1:0] index_o
);

    logic [31:0] crc_q;
    logic [31:0] crc_base;

    // A start byte folds into the seed, not into the previous frame's remainder.
    assign crc_base = init_i ? CRC_SEED : crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (take_i) begin
            crc_q <= crc_byte_step(crc_base, byte_i);
        end
    end

    assign index_o = crc_q[31 -: HASH_BITS];

    // R10
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(crc_q));

endmodule

// File: rtl/daf_addr_track.sv
module daf_addr_track #(
    parameter int ADDR_BYTES = 6,
    localparam int AW        = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [7:0]    byte_i,
    input  logic [AW-1:0] station_i,
    output logic          match_o,
    output logic          bcast_o,
    output logic          group_o
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    generate
        if (ADDR_BYTES > 1) begin : g_shift
            assign addr_d = {addr_q[AW-9:0], byte_i};
        end else begin : g_single
            assign addr_d = byte_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take_i) begin
            addr_q <= addr_d;
        end
    end

    assign match_o = (addr_q == station_i);
    assign bcast_o = &addr_q;
    assign group_o = addr_q[AW-8];

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(addr_q));

endmodule

// File: rtl/daf_ctrl.sv
module daf_ctrl
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int TBL       = 1 << HASH_BITS,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 valid_i,
    input  flt_mode_t            mode_i,
    input  logic [TBL-1:0]       table_i,
    input  logic [HASH_BITS-1:0] index_i,
    input  logic                 match_i,
    input  logic                 bcast_i,
    input  logic                 group_i,
    output logic                 init_o,
    output logic                 take_o,
    output logic                 decide_o,
    output logic                 accept_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    flt_mode_t        cfg_q;
    logic [TBL-1:0]   hash_q;
    logic             verdict;

    assign init_o = valid_i && start_i;
    assign take_o = valid_i && (start_i || (state_q == ST_COLLECT));

    // next state and byte count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (init_o) begin
            cnt_d   = ONE;
            state_d = (ADDR_BYTES == 1) ? ST_DECIDE : ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: begin
                    if (valid_i) begin
                        cnt_d = cnt_q + ONE;
                        if (cnt_q == LAST_IDX) begin
                            state_d = ST_DECIDE;
                        end
                    end
                end
                ST_DECIDE:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // configuration snapshot, taken with the start byte only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            hash_q <= '0;
        end else if (init_o) begin
            cfg_q  <= mode_i;
            hash_q <= table_i;
        end
    end

    // priority: promiscuous, broadcast, group modes, individual match
    always_comb begin
        if (cfg_q.promisc) begin
            verdict = 1'b1;
        end else if (bcast_i) begin
            verdict = 1'b1;
        end else if (group_i) begin
            verdict = cfg_q.all_mcast | (cfg_q.hash_mcast & hash_q[index_i]);
        end else begin
            verdict = match_i;
        end
    end

    // outputs
    always_comb begin
        decide_o = 1'b0;
        accept_o = 1'b0;
        unique case (state_q)
            ST_DECIDE: begin
                decide_o = 1'b1;
                accept_o = verdict;
            end
            ST_IDLE, ST_COLLECT, ST_HOLD: begin
                decide_o = 1'b0;
                accept_o = 1'b0;
            end
            default: begin
                decide_o = 1'b0;
                accept_o = 1'b0;
            end
        endcase
    end

    // R6
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |=> !decide_o);

    // R6
    verdict_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |-> $past(valid_i));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));

    // R4
    unicast_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_o && accept_o && !cfg_q.promisc && !group_i) |-> match_i);

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && !init_o) |=> ($stable(cfg_q) && $stable(hash_q)));

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int TBL       = 1 << HASH_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_start,
    input  logic           rx_valid,
    input  logic [7:0]     rx_byte,
    input  logic [AW-1:0]  station_addr,
    input  logic [TBL-1:0] hash_table,
    input  logic           promisc_en,
    input  logic           all_mcast_en,
    input  logic           hash_mcast_en,
    output logic           filt_valid,
    output logic           filt_accept
);

    logic                 init_w;
    logic                 take_w;
    logic [HASH_BITS-1:0] index_w;
    logic                 match_w;
    logic                 bcast_w;
    logic                 group_w;
    flt_mode_t            mode_w;

    assign mode_w = '{promisc: promisc_en, all_mcast: all_mcast_en, hash_mcast: hash_mcast_en};

    daf_crc_engine #(
        .HASH_BITS (HASH_BITS)
    ) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_w),
        .take_i  (take_w),
        .byte_i  (rx_byte),
        .index_o (index_w)
    );

    daf_addr_track #(
        .ADDR_BYTES (ADDR_BYTES)
    ) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take_w),
        .byte_i    (rx_byte),
        .station_i (station_addr),
        .match_o   (match_w),
        .bcast_o   (bcast_w),
        .group_o   (group_w)
    );

    daf_ctrl #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rx_start),
        .valid_i  (rx_valid),
        .mode_i   (mode_w),
        .table_i  (hash_table),
        .index_i  (index_w),
        .match_i  (match_w),
        .bcast_i  (bcast_w),
        .group_i  (group_w),
        .init_o   (init_w),
        .take_o   (take_w),
        .decide_o (filt_valid),
        .accept_o (filt_accept)
    );

endmodule

// File: tb/rx_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

    typedef struct packed {
        logic [47:0] dest;
        logic        pr;
        logic        am;
        logic        hm;
        logic        hit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{48'h02_11_22_33_44_55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{48'h02_11_22_33_44_56, 1'b0, 1'b0, 1'b0, 1'b0},
        '{48'h00_AA_BB_CC_DD_EE, 1'b1, 1'b0, 1'b0, 1'b0},
        '{48'h01_00_5E_00_00_01, 1'b0, 1'b0, 1'b1, 1'b1},
        '{48'h01_00_5E_00_00_FB, 1'b0, 1'b0, 1'b1, 1'b0},
        '{48'h33_33_00_00_00_01, 1'b0, 1'b1, 1'b0, 1'b0},
        '{48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{48'h01_80_C2_00_00_0E, 1'b0, 1'b0, 1'b0, 1'b1},
        '{48'h01_80_C2_00_00_0E, 1'b1, 1'b0, 1'b1, 1'b0},
        '{48'h02_11_22_33_44_55, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [47:0] station_addr = STATION;
    logic [63:0] hash_table = '0;
    logic        promisc_en = 1'b0;
    logic        all_mcast_en = 1'b0;
    logic        hash_mcast_en = 1'b0;
    logic        filt_valid;
    logic        filt_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rx_dest_filter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_start      (rx_start),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .station_addr  (station_addr),
        .hash_table    (hash_table),
        .promisc_en    (promisc_en),
        .all_mcast_en  (all_mcast_en),
        .hash_mcast_en (hash_mcast_en),
        .filt_valid    (filt_valid),
        .filt_accept   (filt_accept)
    );

    // Reference index: reflected CRC form, then bit-reversed into bits 31:26.
    function automatic logic [5:0] ref_index(input logic [47:0] d);
        logic [31:0] r;
        logic [7:0]  b;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = d[47 - 8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB8_8320;
                else             r = r >> 1;
            end
        end
        return {r[0], r[1], r[2], r[3], r[4], r[5]};
    endfunction

    function automatic logic ref_accept(input logic [47:0] d, input logic pr,
                                        input logic am, input logic hm,
                                        input logic [63:0] tbl);
        if (pr)               return 1'b1;
        if (&d)               return 1'b1;
        if (d[40])            return am | (hm & tbl[ref_index(d)]);
        return d == STATION;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive_byte(input logic st, input logic [7:0] b);
        @(negedge clk);
        rx_start = st;
        rx_valid = 1'b1;
        rx_byte  = b;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        rx_start = 1'b0;
        rx_valid = 1'b0;
    endtask

    // Drives all six bytes with 'gap' idle cycles between them; leaves the
    // last byte on the bus for the next edge.
    task automatic send_addr(input logic [47:0] d, input int gap);
        for (int i = 0; i < 6; i++) begin
            drive_byte(i == 0, d[47 - 8*i -: 8]);
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    idle_cycle();
                    check(filt_valid, 1'b0, "R10 no verdict during gap");
                end
            end
        end
    endtask

    // After the last byte: verdict visible at the next negedge, gone one later.
    task automatic expect_verdict(input logic exp, input string tag);
        idle_cycle();
        check(filt_valid, 1'b1, tag);
        check(filt_accept, exp, tag);
        idle_cycle();
        check(filt_valid, 1'b0, "R6 single-cycle strobe");
    endtask

    task automatic set_modes(input logic pr, input logic am, input logic hm);
        promisc_en    = pr;
        all_mcast_en  = am;
        hash_mcast_en = hm;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] tbl;
        logic [5:0]  idx;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(filt_valid, 1'b0, "R9 strobe low in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(filt_valid, 1'b0, "R9 strobe low after reset");

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            idx = ref_index(VECS[v].dest);
            tbl = VECS[v].hit ? (64'd1 << idx) : ~(64'd1 << idx);
            hash_table = tbl;
            set_modes(VECS[v].pr, VECS[v].am, VECS[v].hm);
            send_addr(VECS[v].dest, 0);
            expect_verdict(ref_accept(VECS[v].dest, VECS[v].pr, VECS[v].am,
                                      VECS[v].hm, tbl),
                           $sformatf("R1-class vector %0d (R2 R3 R4 R5)", v));
        end

        // R10 gaps between bytes, hashed multicast hit
        idx = ref_index(48'h01_00_5E_7F_00_02);
        hash_table = 64'd1 << idx;
        set_modes(1'b0, 1'b0, 1'b1);
        send_addr(48'h01_00_5E_7F_00_02, 2);
        expect_verdict(1'b1, "R10 gapped hashed hit");

        // R1 every table bit except the indexed one set: reject
        hash_table = ~(64'd1 << idx);
        send_addr(48'h01_00_5E_7F_00_02, 0);
        expect_verdict(1'b0, "R1 only indexed bit clear");

        // R6 bytes after the sixth produce nothing
        set_modes(1'b0, 1'b0, 1'b0);
        send_addr(STATION, 0);
        expect_verdict(1'b1, "R4 station before trailing bytes");
        for (int i = 0; i < 8; i++) begin
            drive_byte(1'b0, 8'(i));
            check(filt_valid, 1'b0, "R6 trailing bytes ignored");
        end
        idle_cycle();
        check(filt_valid, 1'b0, "R6 trailing bytes ignored");

        // R7 restart mid-frame, and start without valid ignored
        drive_byte(1'b1, 8'h00);
        drive_byte(1'b0, 8'hAA);
        drive_byte(1'b0, 8'hBB);
        send_addr(STATION, 0);
        expect_verdict(1'b1, "R7 restart mid-frame");
        drive_byte(1'b1, STATION[47:40]);
        drive_byte(1'b0, STATION[39:32]);
        @(negedge clk);
        rx_start = 1'b1;
        rx_valid = 1'b0;
        drive_byte(1'b0, STATION[31:24]);
        drive_byte(1'b0, STATION[23:16]);
        drive_byte(1'b0, STATION[15:8]);
        drive_byte(1'b0, STATION[7:0]);
        expect_verdict(1'b1, "R7 start without valid ignored");

        // R8 mode change mid-frame
        set_modes(1'b0, 1'b0, 1'b0);
        drive_byte(1'b1, 8'h00);
        drive_byte(1'b0, 8'h12);
        set_modes(1'b1, 1'b1, 1'b1);
        drive_byte(1'b0, 8'h34);
        drive_byte(1'b0, 8'h56);
        drive_byte(1'b0, 8'h78);
        drive_byte(1'b0, 8'h9A);
        expect_verdict(1'b0, "R8 promiscuous set mid-frame");

        // R8 table change mid-frame
        hash_table = '0;
        set_modes(1'b0, 1'b0, 1'b1);
        drive_byte(1'b1, 8'h01);
        drive_byte(1'b0, 8'h00);
        hash_table = '1;
        drive_byte(1'b0, 8'h5E);
        drive_byte(1'b0, 8'h01);
        drive_byte(1'b0, 8'h02);
        drive_byte(1'b0, 8'h03);
        expect_verdict(1'b0, "R8 table filled mid-frame");
        hash_table = '1;
        send_addr(48'h01_00_5E_01_02_03, 0);
        expect_verdict(1'b1, "R8 table applies to next frame");

        // R7 verdict and next start byte in the same cycle
        set_modes(1'b0, 1'b0, 1'b0);
        send_addr(48'h02_11_22_33_44_99, 0);
        @(negedge clk);
        check(filt_valid, 1'b1, "R7 verdict beside new start");
        check(filt_accept, 1'b0, "R7 verdict beside new start");
        rx_start = 1'b1;
        rx_valid = 1'b1;
        rx_byte  = 8'hFF;
        for (int i = 1; i < 6; i++) begin
            drive_byte(1'b0, 8'hFF);
            check(filt_valid, 1'b0, "R6 no verdict while collecting");
        end
        expect_verdict(1'b1, "R5 broadcast after overlapped start");

        // R6 plain multicast with no mode rejected
        hash_table = '1;
        send_addr(48'h01_00_5E_00_00_09, 0);
        expect_verdict(1'b0, "R6 multicast with modes clear");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule